// File: doc/BRIEF.md
# Handheld LCD Pixel Stream Capture

This block listens passively to the raw display bus of an old monochrome handheld and rebuilds its picture as a stream of pixels. The bus has three strobes and two data lines: a vertical sync, a horizontal sync, a pixel clock and the high and low bits of a 2-bit grey level. A faster system clock samples all of them. Each bus signal passes through a synchroniser, and edges are found on the synchronised copies. The block then emits one pixel per strobe, with its column and row, and marks the first and last pixel of each frame.

A frame is COLS pixels wide (160 by default) and ROWS lines tall (144 by default). It is sent in raster order from the top-left corner. A frame starts when the vertical sync rises. Each line starts when the horizontal sync rises. While the horizontal sync is still high, the pixel clock makes one pulse that carries no pixel; this pulse is discarded. The data lines are sampled for the first pixel of a line when the horizontal sync falls. The data lines are sampled for each of the remaining pixels of the line when the pixel clock falls. A sticky error flag records a frame that breaks this shape. When the vertical sync rises in the middle of a frame, the block also realigns its counters to the new frame.

The controller is a four-state machine:

- IDLE waits for a frame to begin.
- GAP waits between lines for the horizontal sync to rise.
- LEAD is the time while the horizontal sync is high.
- ACTIVE collects the pixels after the first one.

The transitions are:

- frame-start: IDLE to GAP or LEAD when the vertical sync rises.
- line-start: GAP to LEAD when the horizontal sync rises.
- first-pixel: LEAD to ACTIVE when the horizontal sync falls.
- line-done: ACTIVE to GAP on the last pixel of a line that is not the last line.
- frame-done: ACTIVE to IDLE on the last pixel of the last line.
- cut-line: ACTIVE to LEAD, or to IDLE on the last line, when the horizontal sync rises early.
- resync: any in-frame state to GAP or LEAD when the vertical sync rises.

On every vertical sync rise, the machine enters LEAD if the synchronised horizontal sync is already high, and GAP otherwise.

Top module: `lcd_pixel_capture`

## Requirements
- R1: While reset is held, and right after it is released, pix_valid, pix_value, pix_col, pix_row, pix_sof, pix_eof and frame_err are all 0. Reset also clears a set frame_err.
- R2: No pixel is emitted before the first vertical sync rise. No pixel is emitted after a frame's last pixel until the next vertical sync rise, whatever the horizontal sync and pixel clock do.
- R3: A pixel clock falling edge that occurs while the horizontal sync is high produces no pixel.
- R4: The first pixel of a line is taken at the horizontal sync falling edge. It is reported with pix_col = 0 and pix_value = {data-high, data-low}.
- R5: The remaining pixels of a line are taken one per pixel clock falling edge, with pix_col counting 1 to COLS-1. Lines are reported in order with pix_row counting 0 to ROWS-1. A well-formed frame yields exactly COLS×ROWS pixels.
- R6: pix_sof is 1 only on the pixel at column 0, row 0. pix_eof is 1 only on the pixel at column COLS-1, row ROWS-1.
- R7: pix_valid and the pixel fields appear on the third rising system clock edge after the input edge that carries the pixel (SYNC_STAGES+1 with the default of 2).
- R8: frame_err is set by either of these:
  - a line cut short, meaning the horizontal sync rises before COLS pixels have been taken;
  - a line run long, meaning a pixel clock falling edge arrives between lines.
  
  The extra pulse of a long line produces no pixel.
- R9: A vertical sync rise before the frame's last pixel sets frame_err. The capture then restarts at row 0, and the next pixel is marked pix_sof.
- R10: Once set, frame_err stays 1 through later well-formed frames until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_vsync | input | 1 | Bus vertical sync, asynchronous |
| lcd_hsync | input | 1 | Bus horizontal sync, asynchronous |
| lcd_pclk | input | 1 | Bus pixel clock, asynchronous |
| lcd_d0 | input | 1 | Grey level low bit, asynchronous |
| lcd_d1 | input | 1 | Grey level high bit, asynchronous |
| pix_valid | output | 1 | One-cycle strobe: a pixel is present |
| pix_value | output | 2 | Grey level {d1, d0} |
| pix_col | output | COL_W = clog2(COLS) | Column of the pixel |
| pix_row | output | ROW_W = clog2(ROWS) | Row of the pixel |
| pix_sof | output | 1 | Pixel is the first of its frame |
| pix_eof | output | 1 | Pixel is the last of its frame |
| frame_err | output | 1 | Sticky malformed-frame flag |

## Verification
Each pixel output is due on the third rising system clock edge after the bus edge that carries it. Flag updates from the controller follow the same timing. The bench drives the bus on falling system clock edges and reads outputs only on falling edges. In the latency check it counts exactly two falling edges with nothing present and expects the pixel on the third. Pixel, frame-mark and error counts are read only after at least eight idle system cycles, which is well past the three-cycle pipeline. Each pixel's value is checked against a grey-level formula of frame, row and column, so a pixel sampled one edge early or late shows up as a miscompare.

// File: rtl/lcd_capture_pkg.sv
package lcd_capture_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for a frame start
        ST_GAP    = 2'd1,   // inside a frame, between lines
        ST_LEAD   = 2'd2,   // horizontal sync high, pixel clock ignored
        ST_ACTIVE = 2'd3    // collecting pixels 1..COLS-1
    } cap_state_e;

    // Bus sample as seen after synchronisation
    typedef struct packed {
        logic       vs;
        logic       hs;
        logic       ck;
        logic [1:0] dat;    // {high bit, low bit}
    } lcd_bus_t;

endpackage

// File: rtl/lcd_capture_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// All bits see the same delay so data stays aligned with the strobes.
module lcd_capture_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lcd_capture_edge.sv
// Per-bit edge detector; FALL_MASK chooses falling (1) or rising (0) per bit.
module lcd_capture_edge #(
    parameter int           W         = 4,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] strobe_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (FALL_MASK[b]) begin : g_fall
            assign strobe_o[b] = prev_q[b] & ~level_i[b];
        end else begin : g_rise
            assign strobe_o[b] = ~prev_q[b] & level_i[b];
        end
    end

endmodule

// File: rtl/lcd_capture_fsm.sv
// Frame/line/pixel controller working on synchronised strobes.
module lcd_capture_fsm
    import lcd_capture_pkg::*;
#(
    parameter int COLS  = 160,
    parameter int ROWS  = 144,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_rise,
    input  logic             hs_rise,
    input  logic             hs_fall,
    input  logic             ck_fall,
    input  logic             hs_level,
    input  logic [1:0]       dat,
    output logic             pix_valid,
    output logic [1:0]       pix_value,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row,
    output logic             pix_sof,
    output logic             pix_eof,
    output logic             frame_err
);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    cap_state_e       state_q, state_n;
    logic [COL_W-1:0] col_q, col_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic             emit, err_ev, last_ev;
    logic [COL_W-1:0] emit_col;

    // Next-state and event decode
    always_comb begin
        state_n  = state_q;
        col_n    = col_q;
        row_n    = row_q;
        emit     = 1'b0;
        err_ev   = 1'b0;
        last_ev  = 1'b0;
        emit_col = col_q;
        if (vs_rise) begin
            // frame-start from IDLE, resync from any in-frame state
            err_ev  = (state_q != ST_IDLE);
            row_n   = '0;
            col_n   = '0;
            state_n = hs_level ? ST_LEAD : ST_GAP;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_GAP: begin
                    if (hs_rise) begin
                        state_n = ST_LEAD;          // line-start
                    end else if (ck_fall) begin
                        err_ev  = 1'b1;             // long line
                    end
                end
                ST_LEAD: begin
                    if (hs_fall) begin
                        emit     = 1'b1;            // first-pixel
                        emit_col = '0;
                        col_n    = COL_W'(1);
                        state_n  = ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (hs_rise) begin
                        err_ev = 1'b1;              // cut-line
                        row_n  = row_q + ROW_W'(1);
                        state_n = (row_q == ROW_LAST) ? ST_IDLE : ST_LEAD;
                    end else if (ck_fall) begin
                        emit = 1'b1;
                        if (col_q == COL_LAST) begin
                            if (row_q == ROW_LAST) begin
                                last_ev = 1'b1;     // frame-done
                                state_n = ST_IDLE;
                            end else begin
                                row_n   = row_q + ROW_W'(1);
                                state_n = ST_GAP;   // line-done
                            end
                        end else begin
                            col_n = col_q + COL_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            pix_valid <= 1'b0;
            pix_value <= '0;
            pix_col   <= '0;
            pix_row   <= '0;
            pix_sof   <= 1'b0;
            pix_eof   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            col_q     <= col_n;
            row_q     <= row_n;
            pix_valid <= emit;
            pix_sof   <= emit && (emit_col == '0) && (row_q == '0);
            pix_eof   <= emit && last_ev;
            frame_err <= frame_err | err_ev;
            if (emit) begin
                pix_value <= dat;
                pix_col   <= emit_col;
                pix_row   <= row_q;
            end
        end
    end

    // R5: reported coordinates stay inside the frame
    a_r5_coords_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_col <= COL_LAST && pix_row <= ROW_LAST));

    // R6: start mark only at the origin
    a_r6_sof_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> (pix_valid && pix_col == '0 && pix_row == '0));

    // R6: end mark only at the far corner
    a_r6_eof_at_corner: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eof |-> (pix_valid && pix_col == COL_LAST && pix_row == ROW_LAST));

    // R3: a clock fall while the horizontal sync is high yields nothing
    a_r3_lead_clock_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && ck_fall && !hs_fall && !vs_rise) |=> !pix_valid);

    // R4: horizontal sync fall yields column 0
    a_r4_first_on_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && hs_fall && !vs_rise) |=> (pix_valid && pix_col == '0));

    // R2: nothing emitted while idle
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pix_valid);

    // R8: clock fall between lines flags an error
    a_r8_long_line_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && ck_fall && !vs_rise && !hs_rise) |=> frame_err);

    // R9: vertical sync inside a frame flags an error
    a_r9_resync_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && vs_rise) |=> frame_err);

    // R10: error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

endmodule

// File: rtl/lcd_pixel_capture.sv
// Top: synchronise the bus, find edges, run the capture controller.
module lcd_pixel_capture
    import lcd_capture_pkg::*;
#(
    parameter int COLS        = 160,
    parameter int ROWS        = 144,
    parameter int SYNC_STAGES = 2,
    parameter int COL_W       = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcd_vsync,
    input  logic             lcd_hsync,
    input  logic             lcd_pclk,
    input  logic             lcd_d0,
    input  logic             lcd_d1,
    output logic             pix_valid,
    output logic [1:0]       pix_value,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row,
    output logic             pix_sof,
    output logic             pix_eof,
    output logic             frame_err
);

    localparam int BUS_W  = $bits(lcd_bus_t);
    localparam int EDGE_W = 4;
    // bit3 vsync rise, bit2 hsync rise, bit1 hsync fall, bit0 clock fall
    localparam logic [EDGE_W-1:0] EDGE_FALL = 4'b0011;

    lcd_bus_t          bus_raw;
    lcd_bus_t          bus_sync;
    logic [EDGE_W-1:0] strobes;

    assign bus_raw.vs  = lcd_vsync;
    assign bus_raw.hs  = lcd_hsync;
    assign bus_raw.ck  = lcd_pclk;
    assign bus_raw.dat = {lcd_d1, lcd_d0};

    lcd_capture_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_raw),
        .sync_o  (bus_sync)
    );

    lcd_capture_edge #(
        .W         (EDGE_W),
        .FALL_MASK (EDGE_FALL)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  ({bus_sync.vs, bus_sync.hs, bus_sync.hs, bus_sync.ck}),
        .strobe_o (strobes)
    );

    lcd_capture_fsm #(
        .COLS  (COLS),
        .ROWS  (ROWS),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vs_rise   (strobes[3]),
        .hs_rise   (strobes[2]),
        .hs_fall   (strobes[1]),
        .ck_fall   (strobes[0]),
        .hs_level  (bus_sync.hs),
        .dat       (bus_sync.dat),
        .pix_valid (pix_valid),
        .pix_value (pix_value),
        .pix_col   (pix_col),
        .pix_row   (pix_row),
        .pix_sof   (pix_sof),
        .pix_eof   (pix_eof),
        .frame_err (frame_err)
    );

endmodule

// File: tb/tb_lcd_pixel_capture.sv
`timescale 1ns/1ps
module tb_lcd_pixel_capture;

    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int CW   = 3;
    localparam int RW   = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vs = 1'b0, hs = 1'b0, ck = 1'b0, d0 = 1'b0, d1 = 1'b0;
    logic          pix_valid, pix_sof, pix_eof, frame_err;
    logic [1:0]    pix_value;
    logic [CW-1:0] pix_col;
    logic [RW-1:0] pix_row;

    always #2.5 clk = ~clk;   // 200 MHz

    lcd_pixel_capture #(.COLS(COLS), .ROWS(ROWS), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .lcd_vsync(vs), .lcd_hsync(hs), .lcd_pclk(ck), .lcd_d0(d0), .lcd_d1(d1),
        .pix_valid(pix_valid), .pix_value(pix_value), .pix_col(pix_col),
        .pix_row(pix_row), .pix_sof(pix_sof), .pix_eof(pix_eof), .frame_err(frame_err)
    );

    int n_chk = 0, n_bad = 0;
    int cur_frame = 0;
    bit seq_on = 1'b1;
    bit done = 1'b0;
    int exp_c = 0, exp_r = 0;
    int npix = 0, nsof = 0, neof = 0;

    function automatic logic [1:0] pat(int f, int r, int c);
        return 2'((f * 3 + r * 5 + c * 7 + (c >> 1)) & 3);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pixel monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            npix++;
            if (pix_sof) begin nsof++; exp_c = 0; exp_r = 0; end
            if (pix_eof) neof++;
            check(pix_value == pat(cur_frame, int'(pix_row), int'(pix_col)),
                  "R4 R5 pixel value", int'(pix_value), int'(pat(cur_frame, int'(pix_row), int'(pix_col))));
            check(pix_sof == (pix_col == 0 && pix_row == 0), "R6 sof position",
                  int'(pix_sof), int'(pix_col == 0 && pix_row == 0));
            check(pix_eof == (pix_col == CW'(COLS-1) && pix_row == RW'(ROWS-1)), "R6 eof position",
                  int'(pix_eof), int'(pix_col == CW'(COLS-1) && pix_row == RW'(ROWS-1)));
            if (seq_on) begin
                check(int'(pix_col) == exp_c && int'(pix_row) == exp_r, "R5 raster order",
                      int'(pix_row) * 100 + int'(pix_col), exp_r * 100 + exp_c);
                exp_c++;
                if (exp_c == COLS) begin exp_c = 0; exp_r++; end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_pulse();
        ck = 1'b1; idle(3);
        ck = 1'b0; idle(3);
    endtask

    // One bus line: hsync high with a spurious clock pulse, first pixel on hsync fall,
    // remaining pixels on clock falls.
    task automatic drive_line(int f, int r, int npx, bit first, bit lat);
        hs = 1'b1;
        if (first) vs = 1'b1;
        {d1, d0} = pat(f, r, 0);
        idle(3);
        ck = 1'b1; idle(2);
        ck = 1'b0; idle(2);
        hs = 1'b0;
        if (lat) begin
            idle(2);
            check(!pix_valid, "R7 no pixel before third edge", int'(pix_valid), 0);
            idle(1);
            check(pix_valid && pix_col == 0, "R7 first pixel on third edge", int'(pix_valid), 1);
        end else begin
            idle(3);
        end
        for (int c = 1; c < npx; c++) begin
            {d1, d0} = pat(f, r, c);
            clock_pulse();
        end
        if (first) vs = 1'b0;
        idle(4);
    endtask

    task automatic run_frame(int f, int short_row, int long_row, int nlines, bit lat);
        cur_frame = f;
        for (int r = 0; r < nlines; r++) begin
            drive_line(f, r, (r == short_row) ? COLS - 1 : COLS, r == 0, lat && r == 0);
            if (r == long_row) clock_pulse();
        end
        idle(8);
    endtask

    task automatic clear_counts();
        npix = 0; nsof = 0; neof = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        check(!frame_err && !pix_valid, "R1 reset clears flags", int'(frame_err), 0);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(4);
        check({pix_valid, pix_value, pix_col, pix_row, pix_sof, pix_eof, frame_err} == '0,
              "R1 outputs zero in reset", int'(pix_value), 0);
        rst_n = 1'b1;
        idle(1);
        check({pix_valid, pix_sof, pix_eof, frame_err} == '0, "R1 outputs zero after reset",
              int'(frame_err), 0);

        // R2: lines without a frame start
        clear_counts();
        drive_line(9, 0, COLS, 1'b0, 1'b0);
        drive_line(9, 1, COLS, 1'b0, 1'b0);
        idle(8);
        check(npix == 0, "R2 no pixels before frame start", npix, 0);

        // Two well-formed frames, first with latency probe
        for (int f = 1; f <= 2; f++) begin
            clear_counts();
            run_frame(f, -1, -1, ROWS, f == 1);
            check(npix == COLS * ROWS, "R5 R3 pixel count per frame", npix, COLS * ROWS);
            check(nsof == 1, "R6 one start mark", nsof, 1);
            check(neof == 1, "R6 one end mark", neof, 1);
            check(!frame_err, "R8 no error on good frame", int'(frame_err), 0);
        end

        // R2: bus activity after the frame end
        clear_counts();
        drive_line(2, 0, COLS, 1'b0, 1'b0);
        clock_pulse();
        idle(8);
        check(npix == 0, "R2 silent after frame end", npix, 0);

        // R8: short line
        clear_counts();
        seq_on = 1'b0;
        run_frame(3, 1, -1, ROWS, 1'b0);
        check(frame_err, "R8 short line flagged", int'(frame_err), 1);
        check(npix == COLS * ROWS - 1, "R8 short line pixel count", npix, COLS * ROWS - 1);
        seq_on = 1'b1;

        // R10: flag survives a good frame
        clear_counts();
        run_frame(4, -1, -1, ROWS, 1'b0);
        check(frame_err, "R10 error sticky", int'(frame_err), 1);
        check(npix == COLS * ROWS, "R10 good frame after error", npix, COLS * ROWS);

        // R8: long line, extra pulse produces no pixel
        do_reset();
        clear_counts();
        run_frame(5, -1, 1, ROWS, 1'b0);
        check(frame_err, "R8 long line flagged", int'(frame_err), 1);
        check(npix == COLS * ROWS, "R8 extra pulse dropped", npix, COLS * ROWS);

        // R9: frame cut by an early vertical sync
        do_reset();
        clear_counts();
        run_frame(6, -1, -1, 2, 1'b0);
        check(!frame_err, "R9 no error before resync", int'(frame_err), 0);
        check(npix == 2 * COLS, "R9 partial frame pixels", npix, 2 * COLS);
        clear_counts();
        run_frame(7, -1, -1, ROWS, 1'b1);
        check(frame_err, "R9 early vsync flagged", int'(frame_err), 1);
        check(nsof == 1 && npix == COLS * ROWS, "R9 resynced frame complete", npix, COLS * ROWS);

        // R1: reset clears a set error
        do_reset();
        check(!frame_err, "R1 error cleared by reset", int'(frame_err), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule